// File: doc/BRIEF.md
# Masked Interrupt Level Encoder

This block sits between a board's peripheral interrupt lines and a processor that takes a 4-bit external interrupt level. It watches thirteen level-sensitive request lines. Each line has its own bit in a 16-bit status word and a fixed priority code. A source counts only when its status bit and the matching bit of a software-written mask are both set. The lowest code among the counting sources wins. The block drives the bitwise complement of that code to the processor, so an idle block presents 0 and the most urgent source presents 15.

A small 16-bit register port in a 64-byte window sits beside the encoder. Through it software reads and writes the mask, a general-purpose output latch and a fixed version word, and requests power-off. A power-off request comes out as a one-cycle strobe on a dedicated pin.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Request input i sets status bit B(i) while high and clears it while low. The pairs (input index: status bit) are 0:11, 1:9, 2:8, 3:12, 4:10, 5:6, 6:5, 7:4, 8:7, 9:14, 10:13, 11:0, 12:15. Status bits 1, 2 and 3 are always 0.
- R2: A source with input index i has priority code i. It competes only when status bit B(i) and mask bit B(i) are both 1. The competing source with the smallest code wins.
- R3: `irl_out` is the winning code XOR 15. With no competing source the code is 15 and `irl_out` is 0.
- R4: `irl_out` is registered. It reflects the request inputs and the mask as they stand at a clock edge, starting right after that edge and not before it.
- R5: Reset clears the mask, the output latch and the status word. `irl_out`, `gpo`, `pwr_off_pulse` and `bus_rdata` are then all 0.
- R6: Byte offset 0x00 holds the 16-bit mask. It can be read and written, and a write changes `irl_out` at the same edge that stores the mask.
- R7: Byte offset 0x36 holds a 16-bit output latch. It can be read and written, and it drives `gpo`.
- R8: Byte offset 0x32 always reads 0x0010, and writes to it change nothing.
- R9: Byte offset 0x30 reads 0. A write there with bit 0 set makes `pwr_off_pulse` high for exactly the one cycle after the write edge. A write with bit 0 clear makes no pulse.
- R10: Every other address, including odd byte addresses, reads 0. Writes to those addresses leave the mask and the output latch unchanged.
- R11: A read (`bus_valid`=1, `bus_we`=0) returns its data on `bus_rdata` in the cycle after the access. In all other cycles `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 13 | Level-sensitive request lines, index = priority code |
| bus_valid | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address inside the 64-byte window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read |
| irl_out | output | 4 | Encoded interrupt level (complement of winning code) |
| gpo | output | 16 | General-purpose output latch |
| pwr_off_pulse | output | 1 | One-cycle power-off request strobe |

## Verification
A mask write and a change of the request lines can fall on the same clock edge. The encoder must then combine the new mask with the new requests, not either one with a stale copy of the other. The random phase changes the requests every cycle and writes a random mask in about half of those cycles. After each edge the bench compares `irl_out` with a value it computes itself from the request pattern and its own copy of the mask. A power-off write is also issued in the same cycle as a request change, and both the strobe and the new level are checked one edge later.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int NUM_SRC = 13;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int LVL_W   = 4;
  localparam int BIT_W   = $clog2(DATA_W);

  localparam logic [ADDR_W-1:0] OFF_MASK = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_PWR  = 6'h30;
  localparam logic [ADDR_W-1:0] OFF_VER  = 6'h32;
  localparam logic [ADDR_W-1:0] OFF_GPO  = 6'h36;
  localparam logic [DATA_W-1:0] VERSION  = 16'h0010;
  localparam logic [LVL_W-1:0]  IDLE_CODE = '1;

  // status / mask bit that belongs to request source idx
  function automatic logic [BIT_W-1:0] src_bit(input int idx);
    case (idx)
      0:  return 4'd11;
      1:  return 4'd9;
      2:  return 4'd8;
      3:  return 4'd12;
      4:  return 4'd10;
      5:  return 4'd6;
      6:  return 4'd5;
      7:  return 4'd4;
      8:  return 4'd7;
      9:  return 4'd14;
      10: return 4'd13;
      11: return 4'd0;
      default: return 4'd15;
    endcase
  endfunction

  // lowest competing code, complemented; idle gives 0
  function automatic logic [LVL_W-1:0] lvl_encode(input logic [DATA_W-1:0] stat,
                                                  input logic [DATA_W-1:0] msk);
    logic [LVL_W-1:0] code;
    code = IDLE_CODE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (stat[src_bit(i)] && msk[src_bit(i)]) code = LVL_W'(i);
    end
    return code ^ IDLE_CODE;
  endfunction
endpackage

// File: rtl/lvl_irq_capture.sv
module lvl_irq_capture
  import lvl_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic [DATA_W-1:0]  status_d,
  output logic [DATA_W-1:0]  status_q
);
  always_comb begin
    status_d = '0;
    for (int i = 0; i < NUM_SRC; i++) status_d[src_bit(i)] = irq_req[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  // R1: unmapped status bits never set
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[3:1] == 3'b000);
  // R1: level follows the request line one edge later
  p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[11] |=> status_q[0]);
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] mask_d,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] gpo_q,
  output logic              pwr_pulse,
  output logic [DATA_W-1:0] rdata
);
  logic wr_en, rd_en;
  logic wr_mask, wr_gpo, wr_pwr;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en   = bus_valid && bus_we;
  assign rd_en   = bus_valid && !bus_we;
  assign wr_mask = wr_en && (bus_addr == OFF_MASK);
  assign wr_gpo  = wr_en && (bus_addr == OFF_GPO);
  assign wr_pwr  = wr_en && (bus_addr == OFF_PWR) && bus_wdata[0];
  assign mask_d  = wr_mask ? bus_wdata : mask_q;

  always_comb begin
    case (bus_addr)
      OFF_MASK: rd_mux = mask_q;
      OFF_GPO:  rd_mux = gpo_q;
      OFF_VER:  rd_mux = VERSION;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      gpo_q     <= '0;
      pwr_pulse <= 1'b0;
      rdata     <= '0;
    end else begin
      mask_q    <= mask_d;
      if (wr_gpo) gpo_q <= bus_wdata;
      pwr_pulse <= wr_pwr;
      rdata     <= rd_en ? rd_mux : '0;
    end
  end

  // R6: mask moves only on a write to its offset
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_we && bus_addr == OFF_MASK) |=> $stable(mask_q));
  // R8: version read
  p_version_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_addr == OFF_VER) |=> rdata == 16'h0010);
  // R9: strobe is one cycle wide
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_pulse |=> !pwr_pulse);
  // R9: strobe only after a qualifying write
  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_we && bus_addr == OFF_PWR && bus_wdata[0]) |=> !pwr_pulse);
  // R11: no read, no data
  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_we) |=> rdata == '0);
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               bus_valid,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [LVL_W-1:0]   irl_out,
  output logic [DATA_W-1:0]  gpo,
  output logic               pwr_off_pulse
);
  logic [DATA_W-1:0] status_d, status_q;
  logic [DATA_W-1:0] mask_d, mask_q;
  logic [LVL_W-1:0]  irl_q;

  lvl_irq_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .status_d (status_d),
    .status_q (status_q)
  );

  lvl_irq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mask_d    (mask_d),
    .mask_q    (mask_q),
    .gpo_q     (gpo),
    .pwr_pulse (pwr_off_pulse),
    .rdata     (bus_rdata)
  );

  // encode from next-state values so the level lands on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) irl_q <= '0;
    else        irl_q <= lvl_encode(status_d, mask_d);
  end
  assign irl_out = irl_q;

  // R3: nothing enabled and pending means idle output
  p_out_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & mask_q) == '0) |-> irl_out == '0);
  // R2: source 0 (bit 11) beats every other source
  p_top_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[11] && mask_q[11]) |-> irl_out == 4'hF);
  // R2: source 12 (bit 15) alone gives level 3
  p_low_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & mask_q) == 16'h8000) |-> irl_out == 4'h3);
endmodule

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BMAP [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] irq_req = '0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irl_out;
  logic [15:0] gpo;
  logic        pwr_off_pulse;

  int errors = 0;
  int checks = 0;
  logic [15:0] mask_m = '0;
  logic [15:0] rd_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_ctrl u_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irl_out(irl_out), .gpo(gpo),
    .pwr_off_pulse(pwr_off_pulse)
  );

  function automatic logic [3:0] exp_level(logic [12:0] r, logic [15:0] m);
    for (int c = 0; c < 13; c++)
      if (r[c] && m[BMAP[c]]) return 4'(15 - c);
    return 4'd0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 6'h00) mask_m = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_req_check(logic [12:0] r, string req);
    @(negedge clk);
    irq_req = r;
    @(negedge clk);
    check(irl_out == exp_level(r, mask_m), req, irl_out, exp_level(r, mask_m));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check(irl_out == 0, "R5 irl", irl_out, 0);
    check(gpo == 0, "R5 gpo", gpo, 0);
    check(pwr_off_pulse == 0, "R5 pwr", pwr_off_pulse, 0);
    check(bus_rdata == 0, "R5 rdata", bus_rdata, 0);
    bus_read(6'h00, rd_val);
    check(rd_val == 0, "R5 mask", rd_val, 0);

    // R2: masked-off requests do not count
    set_req_check(13'h1FFF, "R2 mask zero");
    check(irl_out == 0, "R3 idle zero", irl_out, 0);

    // R6 mask write and read back, level changes at the same edge
    bus_write(6'h00, 16'hFFFF);
    check(irl_out == 4'hF, "R6 mask write updates level", irl_out, 4'hF);
    bus_read(6'h00, rd_val);
    check(rd_val == 16'hFFFF, "R6 mask read", rd_val, 16'hFFFF);

    // R1/R2/R3 directed patterns
    set_req_check(13'h1000, "R3 src12 only");
    check(irl_out == 4'h3, "R3 src12 level", irl_out, 4'h3);
    set_req_check(13'h1001, "R2 src0 wins");
    bus_write(6'h00, 16'hF7FF);
    check(irl_out == 4'h3, "R2 src0 masked", irl_out, 4'h3);
    for (int s = 0; s < 13; s++) begin
      bus_write(6'h00, 16'(1) << BMAP[s]);
      set_req_check(13'(1) << s, "R1 bit pairing");
      set_req_check(~(13'(1) << s), "R1 other bits idle");
    end

    // R4: no change before the edge, change right after it
    bus_write(6'h00, 16'hFFFF);
    set_req_check(13'h0000, "R4 idle");
    @(negedge clk);
    irq_req = 13'h0020;
    #1;
    check(irl_out == 0, "R4 not before edge", irl_out, 0);
    @(negedge clk);
    check(irl_out == 4'hA, "R4 after edge", irl_out, 4'hA);

    // R7 output latch
    bus_write(6'h36, 16'hA5C3);
    check(gpo == 16'hA5C3, "R7 gpo port", gpo, 16'hA5C3);
    bus_read(6'h36, rd_val);
    check(rd_val == 16'hA5C3, "R7 gpo read", rd_val, 16'hA5C3);

    // R8 version
    bus_write(6'h32, 16'h1234);
    bus_read(6'h32, rd_val);
    check(rd_val == 16'h0010, "R8 version", rd_val, 16'h0010);

    // R9 power-off strobe
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 6'h30; bus_wdata = 16'h0001;
    irq_req = 13'h0100;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
    check(pwr_off_pulse == 1, "R9 pulse high", pwr_off_pulse, 1);
    check(irl_out == exp_level(13'h0100, mask_m), "R4 level with pwr write",
          irl_out, exp_level(13'h0100, mask_m));
    @(negedge clk);
    check(pwr_off_pulse == 0, "R9 pulse one cycle", pwr_off_pulse, 0);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 6'h30; bus_wdata = 16'hFFFE;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
    check(pwr_off_pulse == 0, "R9 bit0 clear no pulse", pwr_off_pulse, 0);
    bus_read(6'h30, rd_val);
    check(rd_val == 0, "R9 reads zero", rd_val, 0);

    // R10 undefined and odd addresses
    bus_write(6'h3E, 16'h0000);
    bus_write(6'h01, 16'h0000);
    bus_write(6'h37, 16'h0000);
    bus_read(6'h3E, rd_val);
    check(rd_val == 0, "R10 undefined read", rd_val, 0);
    bus_read(6'h01, rd_val);
    check(rd_val == 0, "R10 odd read", rd_val, 0);
    bus_read(6'h00, rd_val);
    check(rd_val == 16'hFFFF, "R10 mask kept", rd_val, 16'hFFFF);
    bus_read(6'h36, rd_val);
    check(rd_val == 16'hA5C3, "R10 gpo kept", rd_val, 16'hA5C3);

    // R11 data only in the cycle after a read
    @(negedge clk);
    check(bus_rdata == 0, "R11 idle rdata", bus_rdata, 0);

    // random: request change and mask write on the same edge
    for (int n = 0; n < 400; n++) begin
      logic [12:0] r;
      logic        do_wr;
      logic [15:0] m;
      r = 13'($urandom);
      do_wr = 1'($urandom);
      m = 16'($urandom);
      @(negedge clk);
      irq_req = r;
      if (do_wr) begin
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 6'h00; bus_wdata = m;
        mask_m = m;
      end
      @(negedge clk);
      bus_valid = 1'b0; bus_we = 1'b0;
      check(irl_out == exp_level(r, mask_m), "R2 random", irl_out, exp_level(r, mask_m));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule